// File: doc/BRIEF.md
# Calibration test-mode stepper with serial trim storage

This block is the factory calibration front end of a detector controller. While the test-enable level is high, a dedicated step clock walks a mode index from T0 up to T11. Each mode gives the shared data, shift-clock, program-enable, strobe and measure pins a different meaning. T0 loads a 14-bit option word serially. T1 to T4 capture four 5-bit thresholds from the present amplifier level. T5 commits those thresholds, together with a 5-bit baseline, into a 25-bit stored word. T6 rotates the complete trim chain out of a serial pin, and can rewrite it in the same pass. T7 to T10 compare a measured level against one of the committed thresholds.

All inputs are treated as levels sampled on the system clock. A clock-like input acts on the clock edge that first samples it high after it was sampled low. The nonvolatile memory behind the stored word is outside this block, and so is the analog measurement path.

Top module: `tm_stepper_top`

## Requirements
- R1: After reset the mode index is 0, the option word, stored word, serial output and compare output are all 0.
- R2: While test enable is high, each step-clock rise advances the mode index by one, up to 11; a rise in mode 11 leaves it at 11.
- R3: While test enable is low the mode index returns to 0 on the next clock, and any thresholds captured in T1 to T4 but not yet committed are discarded (a later commit stores zeros for them).
- R4: In mode 0, a shift-clock rise with program enable high shifts the option word right by one and places the data bit in bit 13, so a word sent least significant bit first ends up in bit order.
- R5: A shift-clock rise with program enable low changes neither the option word nor the stored word.
- R6: In modes 1 to 4, a strobe rise captures the 5-bit level into threshold slot (mode - 1); the stored word does not change until a commit.
- R7: In mode 5, a program-enable rise loads the stored word as {level[4:0] as baseline in bits 24:20, slot 3 in 19:15, slot 2 in 14:10, slot 1 in 9:5, slot 0 in 4:0}.
- R8: In mode 6 the serial output shows bit 0 of the 39-bit chain {stored word, option word}; a shift-clock rise with program enable high rotates the chain right by one with the data bit entering bit 38. Outside mode 6 the serial output is 0.
- R9: In modes 7 to 10, a measure-enable rise sets the compare output to (level > threshold), the threshold being stored-word slot (mode - 7); the output is 0 until the first measurement in a mode and returns to 0 whenever the mode changes.
- R10: A step-clock rise takes precedence: no shift, capture, commit or measurement acts on the clock that advances the mode.
- R11: A rise is an input sampled low on one clock and high on the next; its effect is visible on the outputs after that second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en_i | input | 1 | Test-enable level |
| step_clk_i | input | 1 | Mode step clock |
| prog_clk_i | input | 1 | Serial shift clock |
| prog_en_i | input | 1 | Program enable level |
| prog_data_i | input | 1 | Serial data in |
| latch_i | input | 1 | Threshold capture strobe |
| meas_en_i | input | 1 | Measurement strobe |
| level_i | input | 5 | Amplifier level / measured value |
| mode_o | output | 4 | Current mode index |
| option_o | output | 14 | Option word |
| store_o | output | 25 | Committed stored word |
| serial_o | output | 1 | Serial trim output |
| cmp_o | output | 1 | Compare result |

## Verification
Each input rise is seen one clock after it is driven. Mode, option, stored-word and compare changes therefore appear at the first rising edge that samples the input high, and the serial output follows at once from the new chain state. The bench drives at falling edges and compares every output against its behavioural model at the next falling edge, half a period after the update is due. Directed checks sample at the same point, after each pulse task returns.

// File: rtl/tm_pkg.sv
package tm_pkg;
    localparam int MODE_W = 4;
    localparam logic [MODE_W-1:0] M_OPT       = 4'd0;
    localparam logic [MODE_W-1:0] M_LIM_FIRST = 4'd1;
    localparam logic [MODE_W-1:0] M_COMMIT    = 4'd5;
    localparam logic [MODE_W-1:0] M_SERIAL    = 4'd6;
    localparam logic [MODE_W-1:0] M_CMP_FIRST = 4'd7;
    localparam logic [MODE_W-1:0] M_CMP_LAST  = 4'd10;
    localparam int                LAST_MODE   = 11;
    // bit order of the edge-detector vector
    localparam int EV_STEP  = 4;
    localparam int EV_SCLK  = 3;
    localparam int EV_LATCH = 2;
    localparam int EV_PE    = 1;
    localparam int EV_MEAS  = 0;
    localparam int EV_N     = 5;
endpackage

// File: rtl/tm_edges.sv
module tm_edges #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] in_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] prev;
    } st_t;
    st_t d, q;

    always_comb begin
        d      = q;
        d.prev = in_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    generate
        for (genvar g = 0; g < N; g++) begin : g_rise
            assign rise_o[g] = in_i[g] & ~q.prev[g];
        end
    endgenerate

    // R11
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/tm_mode_ctr.sv
module tm_mode_ctr
    import tm_pkg::*;
#(
    parameter int LAST = LAST_MODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              step_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              chg_o
);
    localparam logic [MODE_W-1:0] LAST_M = MODE_W'(LAST);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
    } st_t;
    st_t d, q;

    always_comb begin
        d = q;
        if (!en_i) begin
            d.mode = '0;
        end else if (step_i && (q.mode < LAST_M)) begin
            d.mode = q.mode + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mode_o = q.mode;
    assign chg_o  = ~en_i | step_i;

    // R2
    mode_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.mode <= LAST_M);
    // R2
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_i && q.mode < LAST_M) |=> (q.mode == $past(q.mode) + 1'b1));
    // R3
    exit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.mode == '0));
endmodule

// File: rtl/tm_trim_regs.sv
module tm_trim_regs
    import tm_pkg::*;
#(
    parameter int OPT_W   = 14,
    parameter int LIM_W   = 5,
    parameter int NUM_LIM = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             en_i,
    input  logic [MODE_W-1:0]                mode_i,
    input  logic                             step_r_i,
    input  logic                             sclk_r_i,
    input  logic                             latch_r_i,
    input  logic                             pe_r_i,
    input  logic                             pe_i,
    input  logic                             sdata_i,
    input  logic [LIM_W-1:0]                 level_i,
    output logic [OPT_W-1:0]                 opt_o,
    output logic [NUM_LIM*LIM_W+LIM_W-1:0]   store_o,
    output logic                             sout_o
);
    localparam int LAT_W   = NUM_LIM * LIM_W;
    localparam int STORE_W = LAT_W + LIM_W;
    localparam int CHAIN_W = STORE_W + OPT_W;

    typedef struct packed {
        logic [OPT_W-1:0]   opt;
        logic [LAT_W-1:0]   lat;
        logic [STORE_W-1:0] store;
    } st_t;
    st_t d, q;

    logic [CHAIN_W-1:0] chain_cur;
    logic [CHAIN_W-1:0] chain_nxt;
    logic               act;

    always_comb begin
        d         = q;
        chain_cur = {q.store, q.opt};
        chain_nxt = {sdata_i, chain_cur[CHAIN_W-1:1]};
        act       = en_i & ~step_r_i;
        if (!en_i) begin
            d.lat = '0;
        end else if (act) begin
            if (mode_i == M_OPT && sclk_r_i && pe_i) begin
                d.opt = {sdata_i, q.opt[OPT_W-1:1]};
            end
            for (int i = 0; i < NUM_LIM; i++) begin
                if (int'(mode_i) == int'(M_LIM_FIRST) + i && latch_r_i) begin
                    d.lat[i*LIM_W +: LIM_W] = level_i;
                end
            end
            if (mode_i == M_COMMIT && pe_r_i) begin
                d.store = {level_i, q.lat};
            end
            if (mode_i == M_SERIAL && sclk_r_i && pe_i) begin
                d.opt   = chain_nxt[OPT_W-1:0];
                d.store = chain_nxt[CHAIN_W-1:OPT_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign opt_o   = q.opt;
    assign store_o = q.store;
    assign sout_o  = (mode_i == M_SERIAL) ? q.opt[0] : 1'b0;

    // R5
    no_pe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pe_i |=> ($stable(q.opt) && $stable(q.store)));
    // R3
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.lat == '0));
    // R6
    store_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != M_COMMIT && mode_i != M_SERIAL) |=> $stable(q.store));
    // R10
    step_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && step_r_i) |=> ($stable(q.opt) && $stable(q.store) && $stable(q.lat)));
endmodule

// File: rtl/tm_compare.sv
module tm_compare
    import tm_pkg::*;
#(
    parameter int LIM_W   = 5,
    parameter int NUM_LIM = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     chg_i,
    input  logic [MODE_W-1:0]        mode_i,
    input  logic                     meas_r_i,
    input  logic [LIM_W-1:0]         level_i,
    input  logic [NUM_LIM*LIM_W-1:0] lims_i,
    output logic                     cmp_o
);
    typedef struct packed {
        logic valid;
        logic res;
    } st_t;
    st_t d, q;

    logic [LIM_W-1:0] lim_sel;
    logic             in_cmp;

    always_comb begin
        d       = q;
        lim_sel = '0;
        in_cmp  = (mode_i >= M_CMP_FIRST) && (mode_i <= M_CMP_LAST);
        for (int i = 0; i < NUM_LIM; i++) begin
            if (int'(mode_i) == int'(M_CMP_FIRST) + i) begin
                lim_sel = lims_i[i*LIM_W +: LIM_W];
            end
        end
        if (chg_i) begin
            d.valid = 1'b0;
            d.res   = 1'b0;
        end else if (in_cmp && meas_r_i) begin
            d.valid = 1'b1;
            d.res   = (level_i > lim_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmp_o = q.valid & q.res;

    // R9
    cmp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_o |-> ((mode_i >= M_CMP_FIRST) && (mode_i <= M_CMP_LAST)));
    // R9
    cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> !cmp_o);
endmodule

// File: rtl/tm_stepper_top.sv
module tm_stepper_top
    import tm_pkg::*;
#(
    parameter int OPT_W   = 14,
    parameter int LIM_W   = 5,
    parameter int NUM_LIM = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           test_en_i,
    input  logic                           step_clk_i,
    input  logic                           prog_clk_i,
    input  logic                           prog_en_i,
    input  logic                           prog_data_i,
    input  logic                           latch_i,
    input  logic                           meas_en_i,
    input  logic [LIM_W-1:0]               level_i,
    output logic [MODE_W-1:0]              mode_o,
    output logic [OPT_W-1:0]               option_o,
    output logic [NUM_LIM*LIM_W+LIM_W-1:0] store_o,
    output logic                           serial_o,
    output logic                           cmp_o
);
    localparam int LAT_W = NUM_LIM * LIM_W;

    logic [EV_N-1:0]   ev_in;
    logic [EV_N-1:0]   ev_rise;
    logic              mode_chg;
    logic [MODE_W-1:0] mode;

    always_comb begin
        ev_in           = '0;
        ev_in[EV_STEP]  = step_clk_i;
        ev_in[EV_SCLK]  = prog_clk_i;
        ev_in[EV_LATCH] = latch_i;
        ev_in[EV_PE]    = prog_en_i;
        ev_in[EV_MEAS]  = meas_en_i;
    end

    tm_edges #(.N(EV_N)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (ev_in),
        .rise_o (ev_rise)
    );

    tm_mode_ctr #(.LAST(LAST_MODE)) u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (test_en_i),
        .step_i (ev_rise[EV_STEP]),
        .mode_o (mode),
        .chg_o  (mode_chg)
    );

    tm_trim_regs #(.OPT_W(OPT_W), .LIM_W(LIM_W), .NUM_LIM(NUM_LIM)) u_trim (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (test_en_i),
        .mode_i    (mode),
        .step_r_i  (ev_rise[EV_STEP]),
        .sclk_r_i  (ev_rise[EV_SCLK]),
        .latch_r_i (ev_rise[EV_LATCH]),
        .pe_r_i    (ev_rise[EV_PE]),
        .pe_i      (prog_en_i),
        .sdata_i   (prog_data_i),
        .level_i   (level_i),
        .opt_o     (option_o),
        .store_o   (store_o),
        .sout_o    (serial_o)
    );

    tm_compare #(.LIM_W(LIM_W), .NUM_LIM(NUM_LIM)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .chg_i    (mode_chg),
        .mode_i   (mode),
        .meas_r_i (ev_rise[EV_MEAS]),
        .level_i  (level_i),
        .lims_i   (store_o[LAT_W-1:0]),
        .cmp_o    (cmp_o)
    );

    assign mode_o = mode;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mode_o == '0 || test_en_i));
endmodule

// File: tb/sim_tm_stepper_top.sv
module sim_tm_stepper_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        test_en = 1'b0, step = 1'b0, sclk = 1'b0, pe = 1'b0, sdat = 1'b0;
    logic        lat = 1'b0, meas = 1'b0;
    logic [4:0]  level = '0;
    logic [3:0]  mode_o;
    logic [13:0] option_o;
    logic [24:0] store_o;
    logic        serial_o, cmp_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tm_stepper_top u0 (
        .clk(clk), .rst_n(rst_n), .test_en_i(test_en), .step_clk_i(step),
        .prog_clk_i(sclk), .prog_en_i(pe), .prog_data_i(sdat), .latch_i(lat),
        .meas_en_i(meas), .level_i(level), .mode_o(mode_o), .option_o(option_o),
        .store_o(store_o), .serial_o(serial_o), .cmp_o(cmp_o)
    );

    // behavioural reference model
    int m_mode = 0;
    int m_lim[4];
    bit chain[$];
    bit m_cv = 0, m_cr = 0;
    bit p_step = 0, p_sclk = 0, p_lat = 0, p_pe = 0, p_meas = 0;

    task automatic model_clear();
        m_mode = 0; m_cv = 0; m_cr = 0;
        foreach (m_lim[k]) m_lim[k] = 0;
        chain.delete();
        for (int k = 0; k < 39; k++) chain.push_back(1'b0);
        p_step = 0; p_sclk = 0; p_lat = 0; p_pe = 0; p_meas = 0;
    endtask

    initial model_clear();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
        end else begin
            bit rs, rc, rl, rp, rm;
            int lim;
            rs = step & !p_step; rc = sclk & !p_sclk; rl = lat & !p_lat;
            rp = pe & !p_pe;     rm = meas & !p_meas;
            if (!test_en) begin
                m_mode = 0; m_cv = 0; m_cr = 0;
                foreach (m_lim[k]) m_lim[k] = 0;
            end else if (rs) begin
                if (m_mode < 11) m_mode++;
                m_cv = 0; m_cr = 0;
            end else begin
                if (m_mode == 0 && rc && pe) begin
                    chain.delete(0);
                    chain.insert(13, sdat);
                end
                if (m_mode >= 1 && m_mode <= 4 && rl) m_lim[m_mode-1] = int'(level);
                if (m_mode == 5 && rp) begin
                    for (int k = 0; k < 4; k++)
                        for (int b = 0; b < 5; b++) chain[14 + k*5 + b] = m_lim[k][b];
                    for (int b = 0; b < 5; b++) chain[34 + b] = level[b];
                end
                if (m_mode == 6 && rc && pe) begin
                    void'(chain.pop_front());
                    chain.push_back(sdat);
                end
                if (m_mode >= 7 && m_mode <= 10 && rm) begin
                    lim = 0;
                    for (int b = 0; b < 5; b++) lim += int'(chain[14 + (m_mode-7)*5 + b]) << b;
                    m_cr = (int'(level) > lim);
                    m_cv = 1;
                end
            end
            p_step = step; p_sclk = sclk; p_lat = lat; p_pe = pe; p_meas = meas;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] m_opt();
        logic [13:0] v;
        for (int b = 0; b < 14; b++) v[b] = chain[b];
        return v;
    endfunction

    function automatic logic [24:0] m_store();
        logic [24:0] v;
        for (int b = 0; b < 25; b++) v[b] = chain[14 + b];
        return v;
    endfunction

    // per-cycle comparison, half a period after each update
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 mode vs model",   64'(mode_o),   64'(m_mode));
            chk("R4 option vs model", 64'(option_o), 64'(m_opt()));
            chk("R7 store vs model",  64'(store_o),  64'(m_store()));
            chk("R8 serial vs model", 64'(serial_o), 64'((m_mode == 6) ? chain[0] : 1'b0));
            chk("R9 cmp vs model",    64'(cmp_o),    64'(m_cv & m_cr));
        end
    end

    task automatic do_step();
        @(negedge clk); step = 1; @(negedge clk); step = 0;
    endtask
    task automatic do_shift(bit d, bit en);
        @(negedge clk); sdat = d; pe = en; sclk = 1;
        @(negedge clk); sclk = 0; pe = 0;
    endtask
    task automatic do_latch(logic [4:0] v);
        @(negedge clk); level = v; lat = 1; @(negedge clk); lat = 0;
    endtask
    task automatic do_commit(logic [4:0] v);
        @(negedge clk); level = v; pe = 1; @(negedge clk); pe = 0;
    endtask
    task automatic do_meas(logic [4:0] v);
        @(negedge clk); level = v; meas = 1; @(negedge clk); meas = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R11 act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        logic [13:0] pat;
        logic [24:0] exp_store;
        logic [38:0] rd;
        pat       = 14'h2A5B;
        exp_store = {5'd7, 5'd31, 5'd5, 5'd20, 5'd10};

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode",   64'(mode_o), 0);
        chk("R1 option", 64'(option_o), 0);
        chk("R1 store",  64'(store_o), 0);
        chk("R1 outs",   64'({serial_o, cmp_o}), 0);

        // step clock ignored while test enable is low (R3)
        do_step();
        chk("R3 step with enable low", 64'(mode_o), 0);

        test_en = 1;
        @(negedge clk);
        // R4 LSB-first option load
        for (int i = 0; i < 14; i++) do_shift(pat[i], 1'b1);
        chk("R4 option word", 64'(option_o), 64'(pat));
        // R5 shifts without program enable
        for (int i = 0; i < 3; i++) do_shift(1'b1, 1'b0);
        chk("R5 option unchanged", 64'(option_o), 64'(pat));

        // R10 step and shift on the same clock
        @(negedge clk); step = 1; sclk = 1; pe = 1; sdat = 0;
        @(negedge clk); step = 0; sclk = 0; pe = 0;
        chk("R10 mode advanced", 64'(mode_o), 1);
        chk("R10 option unchanged", 64'(option_o), 64'(pat));

        // R6 capture thresholds T1..T4
        do_latch(5'd10); do_step();
        do_latch(5'd20); do_step();
        do_latch(5'd5);  do_step();
        do_latch(5'd31);
        chk("R6 store not yet written", 64'(store_o), 0);
        chk("R2 mode T4", 64'(mode_o), 4);

        // R7 commit in T5
        do_step();
        do_commit(5'd7);
        chk("R7 committed word", 64'(store_o), 64'(exp_store));

        // R8 serial read with loop-back write in T6
        do_step();
        for (int i = 0; i < 39; i++) begin
            @(negedge clk);
            rd[i] = serial_o;
            do_shift(serial_o, 1'b1);
        end
        chk("R8 serial readout", 64'(rd), 64'({exp_store, pat}));
        chk("R8 chain restored", 64'({store_o, option_o}), 64'({exp_store, pat}));

        // R9 compares T7..T10
        do_step();
        chk("R9 no result before measure", 64'(cmp_o), 0);
        do_meas(5'd11);
        chk("R9 T7 11>10", 64'(cmp_o), 1);
        do_step();
        chk("R9 cleared on mode change", 64'(cmp_o), 0);
        do_meas(5'd20);
        chk("R9 T8 equal", 64'(cmp_o), 0);
        do_step();
        do_meas(5'd6);
        chk("R9 T9 6>5", 64'(cmp_o), 1);
        do_step();
        do_meas(5'd30);
        chk("R9 T10 30<31", 64'(cmp_o), 0);
        do_meas(5'd0);
        do_step();
        chk("R2 mode T11", 64'(mode_o), 11);
        do_step();
        chk("R2 saturate at T11", 64'(mode_o), 11);
        chk("R8 serial low outside T6", 64'(serial_o), 0);

        // R3 exit and discard
        @(negedge clk); test_en = 0;
        @(negedge clk);
        chk("R3 mode back to 0", 64'(mode_o), 0);
        test_en = 1;
        do_step();
        do_latch(5'd9);
        @(negedge clk); test_en = 0;
        @(negedge clk); test_en = 1;
        for (int i = 0; i < 5; i++) do_step();
        chk("R11 mode T5 after steps", 64'(mode_o), 5);
        do_commit(5'd3);
        chk("R3 uncommitted limit discarded", 64'(store_o), 64'({5'd3, 20'd0}));
        chk("R5 option kept over exit", 64'(option_o), 64'(pat));

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule